// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Error Flags

This block turns an asynchronous serial input into parallel characters. A baud-rate enable strobe that pulses sixteen times per bit period paces it. The line first passes through a synchronizer. A falling edge starts a candidate start bit, and the block checks that bit again at its midpoint before it accepts a character. It then samples each data bit, the optional parity bit and one or two stop bits at the middle of the bit.

Each finished character is written into a holding register, and the ready flag is raised. Three further flags record errors: overrun, parity mismatch and framing. A read strobe clears the ready flag. A separate status-clear pulse clears the three error flags. Character length, parity mode and stop-bit count come from static configuration inputs. The baud generator and any bus logic sit outside this block.

Top module: `rx_char_engine`

## Requirements
- R1: A frame is received as a low start bit, then data bits least significant bit first, then the optional parity bit, then the stop bit(s). The data bits go into `rx_data`, and `rx_ready` goes high.
- R2: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `rx_data` above the selected length read as zero.
- R3: `cfg_parity` selects the parity mode: 0 even, 1 odd, 2 parity bit always 0, 3 parity bit always 1, and 4 to 7 no parity bit. If the received parity bit differs from the expected one, `err_parity` is set. With no parity, no parity bit is sampled and no check is made.
- R4: `err_frame` is set only when a sampled stop bit is low and at least one received data bit is high. An all-zero character with a low stop bit is still delivered, and no framing error is flagged for it. After a low stop bit, the receiver waits for the line to return high before it looks for a new start bit.
- R5: If a character completes while `rx_ready` is still set and `rd_strobe` is not asserted in that cycle, `err_overrun` is set. The holding register then takes the new character.
- R6: A low pulse shorter than half a bit period is rejected as a glitch, because the start bit is confirmed at its midpoint. No character results and `rx_ready` stays low.
- R7: `rd_strobe` clears `rx_ready`. `err_overrun`, `err_parity` and `err_frame` stay set until a `clr_status` pulse; a read strobe alone does not clear them.
- R8: When `cfg_two_stop` is 1, two stop bits are sampled. A low level in either of them, together with a nonzero character, sets `err_frame`.
- R9: After reset, `rx_data` is zero and all four flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Enable strobe, 16 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length select (0..3 gives 5..8 bits) |
| cfg_parity | input | 3 | Parity mode select |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rd_strobe | input | 1 | Holding-register read; clears ready |
| clr_status | input | 1 | Clears overrun, parity and framing flags |
| rx_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | New character available |
| err_overrun | output | 1 | Character lost before read |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | Low stop bit with nonzero data seen |

## Verification
The receiver is driven with patterns of alternating bits, all-ones and sparse bits, so that a bit-order or bit-index mistake shows up as a wrong value.

Short characters are sent with ones just above the top data bit, which separates correct length handling and zero-masking from reading past the end of the character. Each parity mode gets both a correct and a wrong parity bit, so an inverted or ignored check is exposed.

A nonzero character with a low stop bit is contrasted with an all-zero break, followed by a long low and then a normal character; this tells the framing rule and the wait-for-high recovery apart. A short low pulse, two unread characters and a bad second stop bit test glitch rejection, overrun and two-stop-bit checking.

// File: rtl/rx_char_pkg.sv
package rx_char_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2,
        ST_BRK
    } rx_state_t;

    typedef enum logic [2:0] {
        PAR_EVEN = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_ZERO = 3'd2,
        PAR_ONE  = 3'd3
    } par_mode_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

    // Index of the last data bit for a length code (0..3 -> 5..8 bits).
    function automatic logic [2:0] last_bit_idx(input logic [1:0] len_code);
        return 3'd4 + {1'b0, len_code};
    endfunction

    // Parity modes 4..7 carry no parity bit.
    function automatic logic parity_enabled(input logic [2:0] mode);
        return !mode[2];
    endfunction

    // Value the parity bit should have; unused data bits are zero.
    function automatic logic expected_parity(input logic [DATA_W-1:0] d,
                                             input logic [2:0] mode);
        logic r;
        case (mode)
            PAR_EVEN: r = ^d;
            PAR_ODD:  r = ~^d;
            PAR_ZERO: r = 1'b0;
            PAR_ONE:  r = 1'b1;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_char_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_len,
    input  logic [2:0] cfg_par,
    input  logic       cfg_two_stop,
    output rx_char_t   chr,
    output logic       chr_valid
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              stop_bad;
    logic              at_mid, at_last;

    assign at_mid  = (cnt == MID);
    assign at_last = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            stop_bad  <= 1'b0;
            chr       <= '0;
            chr_valid <= 1'b0;
        end else begin
            chr_valid <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (!line) state <= ST_START;
                    end
                    ST_START: begin
                        if (at_mid) begin
                            cnt <= '0;
                            if (line) begin
                                state <= ST_IDLE;
                            end else begin
                                state    <= ST_DATA;
                                idx      <= '0;
                                shreg    <= '0;
                                stop_bad <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_last) begin
                            cnt        <= '0;
                            shreg[idx] <= line;
                            if (idx == last_bit_idx(cfg_len))
                                state <= parity_enabled(cfg_par) ? ST_PAR : ST_STOP;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_last) begin
                            cnt     <= '0;
                            par_bit <= line;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP, ST_STOP2: begin
                        if (at_last) begin
                            cnt <= '0;
                            if (state == ST_STOP && cfg_two_stop) begin
                                stop_bad <= !line;
                                state    <= ST_STOP2;
                            end else begin
                                chr_valid    <= 1'b1;
                                chr.data     <= shreg;
                                chr.par_err  <= parity_enabled(cfg_par) &&
                                                (par_bit != expected_parity(shreg, cfg_par));
                                chr.frm_err  <= (stop_bad || !line) && (|shreg);
                                state        <= (stop_bad || !line) ? ST_BRK : ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BRK: begin
                        cnt <= '0;
                        if (line) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
    import rx_char_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_char_t          chr,
    input  logic              chr_valid,
    input  logic              rd_strobe,
    input  logic              clr_status,
    output logic [DATA_W-1:0] hold,
    output logic              ready,
    output logic              ovr,
    output logic              perr,
    output logic              ferr
);
    logic ovr_keep, perr_keep, ferr_keep;

    assign ovr_keep  = ovr  && !clr_status;
    assign perr_keep = perr && !clr_status;
    assign ferr_keep = ferr && !clr_status;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
        end else if (chr_valid) begin
            hold  <= chr.data;
            ready <= 1'b1;
            ovr   <= ovr_keep  || (ready && !rd_strobe);
            perr  <= perr_keep || chr.par_err;
            ferr  <= ferr_keep || chr.frm_err;
        end else begin
            if (rd_strobe) ready <= 1'b0;
            ovr  <= ovr_keep;
            perr <= perr_keep;
            ferr <= ferr_keep;
        end
    end
endmodule

// File: rtl/rx_char_engine.sv
module rx_char_engine
    import rx_char_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_16x,
    input  logic              rx_line,
    input  logic [1:0]        cfg_len,
    input  logic [2:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic              rd_strobe,
    input  logic              clr_status,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_frame
);
    logic     line_s;
    rx_char_t chr;
    logic     chr_valid;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    rx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_16x),
        .line         (line_s),
        .cfg_len      (cfg_len),
        .cfg_par      (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .chr          (chr),
        .chr_valid    (chr_valid)
    );

    rx_status_regs u_stat (
        .clk        (clk),
        .rst        (rst),
        .chr        (chr),
        .chr_valid  (chr_valid),
        .rd_strobe  (rd_strobe),
        .clr_status (clr_status),
        .hold       (rx_data),
        .ready      (rx_ready),
        .ovr        (err_overrun),
        .perr       (err_parity),
        .ferr       (err_frame)
    );
endmodule

// File: rtl/rx_char_engine_checker.sv
module rx_char_engine_checker (
    input logic       clk,
    input logic       rst,
    input logic       chr_valid,
    input logic       rd_strobe,
    input logic       clr_status,
    input logic [7:0] rx_data,
    input logic       rx_ready,
    input logic       err_overrun,
    input logic       err_parity,
    input logic       err_frame
);
    p_ready_on_char_r1: assert property (@(posedge clk) disable iff (rst)
        chr_valid |=> rx_ready);

    p_hold_stable_r1: assert property (@(posedge clk) disable iff (rst)
        !chr_valid |=> $stable(rx_data));

    p_overrun_set_r5: assert property (@(posedge clk) disable iff (rst)
        (chr_valid && rx_ready && !rd_strobe) |=> err_overrun);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !chr_valid) |=> !rx_ready);

    p_frame_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err_frame && !clr_status) |=> err_frame);

    p_parity_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err_parity && !clr_status) |=> err_parity);

    p_clear_errors_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_status && !chr_valid) |=> (!err_overrun && !err_parity && !err_frame));
endmodule

bind rx_char_engine rx_char_engine_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .chr_valid   (chr_valid),
    .rd_strobe   (rd_strobe),
    .clr_status  (clr_status),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .err_frame   (err_frame)
);

// File: tb/rx_char_engine_bench.sv
`timescale 1ns/1ps
module rx_char_engine_bench;
    localparam int BIT_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [2:0] cfg_parity = 3'd4;
    logic       cfg_two_stop = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       clr_status = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_overrun, err_parity, err_frame;
    logic [1:0] div = '0;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        div      <= div + 1'b1;
        tick_16x <= (div == 2'd3);
    end

    rx_char_engine u_rx_char_engine (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .rd_strobe(rd_strobe), .clr_status(clr_status), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_overrun(err_overrun), .err_parity(err_parity),
        .err_frame(err_frame)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input int bits);
        rx_line = b;
        repeat (bits * BIT_CLKS) @(negedge clk);
    endtask

    // Sends one frame; parity bit sent when has_par, then nstop stop bits.
    task automatic send_frame(input logic [7:0] d, input int nbits, input bit has_par,
                              input logic pbit, input logic s1, input logic s2,
                              input int nstop);
        drive_bit(1'b0, 1);
        for (int i = 0; i < nbits; i++) drive_bit(d[i], 1);
        if (has_par) drive_bit(pbit, 1);
        drive_bit(s1, 1);
        if (nstop == 2) drive_bit(s2, 1);
        drive_bit(1'b1, 1);
    endtask

    task automatic pulse_rd_clr();
        rd_strobe = 1'b1; clr_status = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0; clr_status = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R9 data", rx_data, 0);
        check("R9 flags", {rx_ready, err_overrun, err_parity, err_frame}, 0);
    endtask

    task automatic t_basic();
        cfg_len = 2'd3; cfg_parity = 3'd4; cfg_two_stop = 1'b0;
        pulse_rd_clr();
        send_frame(8'hA5, 8, 0, 0, 1, 1, 1);
        check("R1 data", rx_data, 8'hA5);
        check("R1 ready", rx_ready, 1);
        check("R1 no errors", {err_overrun, err_parity, err_frame}, 0);
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
        check("R7 read clears ready", rx_ready, 0);
        send_frame(8'h01, 8, 0, 0, 1, 1, 1);
        check("R1 lsb first", rx_data, 8'h01);
    endtask

    task automatic t_lengths();
        pulse_rd_clr();
        cfg_len = 2'd0;
        send_frame(8'h1F, 5, 0, 0, 1, 1, 1);
        check("R2 five bits", rx_data, 8'h1F);
        check("R2 five bits no frame err", err_frame, 0);
        pulse_rd_clr();
        cfg_len = 2'd2;
        send_frame(8'h55, 7, 0, 0, 1, 1, 1);
        check("R2 seven bits", rx_data, 8'h55);
        pulse_rd_clr();
        cfg_len = 2'd1;
        send_frame(8'h2A, 6, 0, 0, 1, 1, 1);
        check("R2 six bits", rx_data, 8'h2A);
        cfg_len = 2'd3;
    endtask

    task automatic t_parity();
        pulse_rd_clr();
        cfg_parity = 3'd0;
        send_frame(8'h07, 8, 1, 1'b1, 1, 1, 1);
        check("R3 even good", err_parity, 0);
        check("R3 data with parity", rx_data, 8'h07);
        pulse_rd_clr();
        cfg_parity = 3'd1;
        send_frame(8'h07, 8, 1, 1'b1, 1, 1, 1);
        check("R3 odd bad", err_parity, 1);
        pulse_rd_clr();
        cfg_parity = 3'd1;
        send_frame(8'h03, 8, 1, 1'b1, 1, 1, 1);
        check("R3 odd good", err_parity, 0);
        pulse_rd_clr();
        cfg_parity = 3'd3;
        send_frame(8'h00, 8, 1, 1'b1, 1, 1, 1);
        check("R3 forced one good", err_parity, 0);
        pulse_rd_clr();
        cfg_parity = 3'd2;
        send_frame(8'h00, 8, 1, 1'b1, 1, 1, 1);
        check("R3 forced zero bad", err_parity, 1);
        pulse_rd_clr();
        cfg_parity = 3'd4;
        send_frame(8'h81, 8, 0, 0, 1, 1, 1);
        check("R3 none no check", err_parity, 0);
        check("R3 none data", rx_data, 8'h81);
    endtask

    task automatic t_framing();
        pulse_rd_clr();
        send_frame(8'h3C, 8, 0, 0, 0, 1, 1);
        check("R4 frame error", err_frame, 1);
        pulse_rd_clr();
        drive_bit(1'b0, 10);
        check("R4 break delivered", rx_ready, 1);
        check("R4 break data", rx_data, 0);
        check("R4 break no frame err", err_frame, 0);
        drive_bit(1'b0, 3);
        drive_bit(1'b1, 1);
        pulse_rd_clr();
        send_frame(8'hC3, 8, 0, 0, 1, 1, 1);
        check("R4 recover after break", rx_data, 8'hC3);
        check("R4 recover no frame err", err_frame, 0);
    endtask

    task automatic t_overrun();
        pulse_rd_clr();
        send_frame(8'h11, 8, 0, 0, 1, 1, 1);
        check("R5 no overrun first", err_overrun, 0);
        send_frame(8'h22, 8, 0, 0, 1, 1, 1);
        check("R5 overrun", err_overrun, 1);
        check("R5 newest kept", rx_data, 8'h22);
    endtask

    task automatic t_glitch();
        pulse_rd_clr();
        rx_line = 1'b0;
        repeat (16) @(negedge clk);
        drive_bit(1'b1, 3);
        check("R6 glitch ignored", rx_ready, 0);
        send_frame(8'h5A, 8, 0, 0, 1, 1, 1);
        check("R6 next frame ok", rx_data, 8'h5A);
    endtask

    task automatic t_sticky();
        pulse_rd_clr();
        cfg_parity = 3'd0;
        send_frame(8'h01, 8, 1, 1'b0, 0, 1, 1);
        cfg_parity = 3'd4;
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 errors survive read", {err_parity, err_frame}, 2'b11);
        check("R7 ready cleared", rx_ready, 0);
        clr_status = 1'b1; @(negedge clk); clr_status = 1'b0; @(negedge clk);
        check("R7 clear status", {err_overrun, err_parity, err_frame}, 0);
    endtask

    task automatic t_two_stop();
        pulse_rd_clr();
        cfg_two_stop = 1'b1;
        send_frame(8'h42, 8, 0, 0, 1, 0, 2);
        check("R8 second stop low", err_frame, 1);
        pulse_rd_clr();
        send_frame(8'h42, 8, 0, 0, 1, 1, 2);
        check("R8 two stops good", err_frame, 0);
        check("R8 data", rx_data, 8'h42);
        cfg_two_stop = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_framing();
        t_overrun();
        t_glitch();
        t_sticky();
        t_two_stop();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule